// File: doc/BRIEF.md
# External Bus Address and Chip-Select Unit

This unit drives the address side of an external memory bus for a small controller core. When the core presents an external access, the unit captures the 24-bit address and drives it onto 24 address pins. At the same edge it chooses an 8-bit or a 16-bit data bus width for the external space being accessed. The topmost address pin carries the inverse of address bit 23. The pins for bits 20 to 23 can instead carry up to four active-low chip selects.

A 2-bit chip-select mode chooses how many of these four shared pins become chip selects. Each chip select is decoded from a fixed 1 MB address window near the top of the space. A per-space byte-bus register chooses the data width for each space. For the strap space, the reset value of this register bit comes from a strap pin. Both configuration values are written through a single write port and take effect from the next access onward. The outputs are registered and hold their values between accesses.

Top module: `ext_bus_addr_cs`

## Requirements
- R1: On an access, pins 19..0 carry address bits 19..0 of that access.
- R2: Pins and bus width update only at a clock edge where `ext_req` is high, and hold their values at every other edge.
- R3: Mode encoding for pins 23..20: 00 gives CS0..CS3 on pins 23,22,21,20. 01 gives CS0..CS2 on pins 23..21, with pin 20 carrying address bit 20. 10 gives CS0,CS1 on pins 23,22, with pins 21,20 carrying address bits. 11 gives pin 23 = inverted address bit 23, with pins 22..20 carrying address bits.
- R4: An enabled chip select CSi is low exactly when address bits 23..20 equal 15-i (CS0 = F, CS1 = E, CS2 = D, CS3 = C) and high otherwise. An address outside every enabled window drives all enabled chip selects high.
- R5: After synchronous reset the mode is 11, the pins read 0x800000 and `bus_wide` is 0.
- R6: Byte-bus bit i = 1 selects an 8-bit bus (`bus_wide` = 0) and 0 selects a 16-bit bus (`bus_wide` = 1) for an access with `ext_space` = i.
- R7: At reset, byte-bus bit 3 loads the `byte_strap` level (high gives 8-bit) and bits 0..2 load 0 (16-bit).
- R8: A configuration write at an edge affects only later accesses. An access sampled at the same edge uses the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_strap | input | 1 | Reset default of the strap space width (1 = 8-bit) |
| cfg_we | input | 1 | Configuration write enable |
| cfg_cs_mode | input | 2 | Chip-select mode to write |
| cfg_byte_bus | input | 4 | Byte-bus bits to write, one per space |
| ext_req | input | 1 | External access strobe |
| ext_addr | input | 24 | Internal address of the access |
| ext_space | input | 2 | External space index of the access |
| addr_pins | output | 24 | Address pins, high pins shared with chip selects |
| bus_wide | output | 1 | 1 = 16-bit data bus for the current access |

## Verification
A configuration write and an external access can land on the same clock edge. The bench provokes this by raising `cfg_we` and `ext_req` in one cycle. It uses an address whose pin pattern differs between the old mode and the new mode, and a space whose width bit changes. The bench expects the pre-write pattern and width from that access. It expects the new ones from the following access.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  localparam int CS_MAX = 4;

  typedef enum logic [1:0] {
    CSM_FOUR  = 2'b00,
    CSM_THREE = 2'b01,
    CSM_TWO   = 2'b10,
    CSM_A23N  = 2'b11
  } cs_mode_e;

  // number of shared pins acting as true window chip selects
  function automatic int cs_count(cs_mode_e m);
    return (m == CSM_A23N) ? 0 : CS_MAX - int'(m);
  endfunction
endpackage

// File: rtl/ebus_cfg_regs.sv
module ebus_cfg_regs
  import ebus_pkg::*;
#(
  parameter int NUM_SPACES = 4,
  parameter int STRAP_SPACE = 3,
  parameter logic [NUM_SPACES-1:0] BYTE_RST = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  byte_strap,
  input  logic                  we,
  input  logic [1:0]            mode_wdata,
  input  logic [NUM_SPACES-1:0] byte_wdata,
  output cs_mode_e              mode_q,
  output logic [NUM_SPACES-1:0] byte_q
);
  always_ff @(posedge clk) begin
    if (rst) mode_q <= CSM_A23N;
    else if (we) mode_q <= cs_mode_e'(mode_wdata);
  end

  for (genvar s = 0; s < NUM_SPACES; s++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) byte_q[s] <= (s == STRAP_SPACE) ? byte_strap : BYTE_RST[s];
      else if (we) byte_q[s] <= byte_wdata[s];
    end
  end
endmodule

// File: rtl/ebus_cs_decode.sv
module ebus_cs_decode
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WIN_SHIFT = 20,
  localparam int TAG_W = ADDR_W - WIN_SHIFT
) (
  input  logic [TAG_W-1:0]  tag,
  output logic [CS_MAX-1:0] hit
);
  localparam logic [TAG_W-1:0] TOP_TAG = '1;

  // window i sits i windows below the top of the space
  for (genvar i = 0; i < CS_MAX; i++) begin : g_win
    localparam logic [TAG_W-1:0] WIN_TAG = TOP_TAG - TAG_W'(i);
    assign hit[i] = (tag == WIN_TAG);
  end
endmodule

// File: rtl/ebus_pin_mux.sv
module ebus_pin_mux
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  cs_mode_e          mode,
  input  logic [CS_MAX-1:0] hit,
  output logic [ADDR_W-1:0] pins
);
  localparam int LOW_W = ADDR_W - CS_MAX;

  assign pins[LOW_W-1:0] = addr[LOW_W-1:0];

  for (genvar i = 0; i < CS_MAX; i++) begin : g_shared
    localparam int P = ADDR_W - 1 - i;
    logic as_cs;
    assign as_cs = (i < cs_count(mode));
    if (i == 0) begin : g_top
      assign pins[P] = as_cs ? ~hit[i] : ~addr[P];
    end else begin : g_mid
      assign pins[P] = as_cs ? ~hit[i] : addr[P];
    end
  end
endmodule

// File: rtl/ext_bus_addr_cs.sv
module ext_bus_addr_cs
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NUM_SPACES = 4,
  parameter int WIN_SHIFT = 20,
  parameter int STRAP_SPACE = 3,
  parameter logic [NUM_SPACES-1:0] BYTE_RST = '0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          byte_strap,
  input  logic                          cfg_we,
  input  logic [1:0]                    cfg_cs_mode,
  input  logic [NUM_SPACES-1:0]         cfg_byte_bus,
  input  logic                          ext_req,
  input  logic [ADDR_W-1:0]             ext_addr,
  input  logic [$clog2(NUM_SPACES)-1:0] ext_space,
  output logic [ADDR_W-1:0]             addr_pins,
  output logic                          bus_wide
);
  localparam logic [ADDR_W-1:0] PINS_RST = {1'b1, {(ADDR_W-1){1'b0}}};

  cs_mode_e              mode_q;
  logic [NUM_SPACES-1:0] byte_q;
  logic [CS_MAX-1:0]     hit;
  logic [ADDR_W-1:0]     pins_nxt;

  ebus_cfg_regs #(
    .NUM_SPACES(NUM_SPACES), .STRAP_SPACE(STRAP_SPACE), .BYTE_RST(BYTE_RST)
  ) u_cfg (
    .clk(clk), .rst(rst), .byte_strap(byte_strap), .we(cfg_we),
    .mode_wdata(cfg_cs_mode), .byte_wdata(cfg_byte_bus),
    .mode_q(mode_q), .byte_q(byte_q)
  );

  ebus_cs_decode #(.ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT)) u_dec (
    .tag(ext_addr[ADDR_W-1:WIN_SHIFT]), .hit(hit)
  );

  ebus_pin_mux #(.ADDR_W(ADDR_W)) u_mux (
    .addr(ext_addr), .mode(mode_q), .hit(hit), .pins(pins_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_pins <= PINS_RST;
      bus_wide  <= 1'b0;
    end else if (ext_req) begin
      addr_pins <= pins_nxt;
      bus_wide  <= ~byte_q[ext_space];
    end
  end
endmodule

// File: rtl/ebus_chk.sv
module ebus_chk
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              ext_req,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] addr_pins,
  input logic              bus_wide,
  input cs_mode_e          mode_q
);
  localparam int LOW_W = ADDR_W - CS_MAX;

  p_low_bits_r1: assert property (@(posedge clk) disable iff (rst)
    ext_req |=> addr_pins[LOW_W-1:0] == $past(ext_addr[LOW_W-1:0]));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ext_req |=> $stable(addr_pins) && $stable(bus_wide));

  p_a23n_r3: assert property (@(posedge clk) disable iff (rst)
    (ext_req && mode_q == CSM_A23N) |=>
      (addr_pins[ADDR_W-1] == !$past(ext_addr[ADDR_W-1])) &&
      (addr_pins[ADDR_W-2:LOW_W] == $past(ext_addr[ADDR_W-2:LOW_W])));

  p_cs_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    (ext_req && mode_q == CSM_FOUR) |=> $onehot0(~addr_pins[ADDR_W-1:LOW_W]));

  p_reset_r5: assert property (@(posedge clk)
    rst |=> (addr_pins == {1'b1, {(ADDR_W-1){1'b0}}}) && !bus_wide);
endmodule

bind ext_bus_addr_cs ebus_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ext_req(ext_req), .ext_addr(ext_addr),
  .addr_pins(addr_pins), .bus_wide(bus_wide), .mode_q(mode_q)
);

// File: tb/sim_ext_bus_addr_cs.sv
module sim_ext_bus_addr_cs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_strap = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_cs_mode = 2'b00;
  logic [3:0] cfg_byte_bus = 4'h0;
  logic ext_req = 1'b0;
  logic [23:0] ext_addr = 24'h0;
  logic [1:0] ext_space = 2'd0;
  logic [23:0] addr_pins;
  logic bus_wide;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ext_bus_addr_cs u0 (
    .clk(clk), .rst(rst), .byte_strap(byte_strap), .cfg_we(cfg_we),
    .cfg_cs_mode(cfg_cs_mode), .cfg_byte_bus(cfg_byte_bus), .ext_req(ext_req),
    .ext_addr(ext_addr), .ext_space(ext_space), .addr_pins(addr_pins),
    .bus_wide(bus_wide)
  );

  // {mode, byte bits, addr, space, expected pins, expected bus_wide}
  typedef logic [1+2+4+24+2+24-1:0] vec_t;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    {2'b00, 4'b0000, 24'hF12345, 2'd0, 24'h712345, 1'b1},
    {2'b00, 4'b0001, 24'hE0ABCD, 2'd0, 24'hB0ABCD, 1'b0},
    {2'b00, 4'b0000, 24'hD00001, 2'd1, 24'hD00001, 1'b1},
    {2'b00, 4'b0000, 24'hC55555, 2'd2, 24'hE55555, 1'b1},
    {2'b00, 4'b0100, 24'h3FFFFF, 2'd2, 24'hFFFFFF, 1'b0},
    {2'b01, 4'b1111, 24'h400000, 2'd3, 24'hE00000, 1'b0},
    {2'b10, 4'b0000, 24'hE07777, 2'd3, 24'hA07777, 1'b1},
    {2'b11, 4'b1000, 24'hF00010, 2'd3, 24'h700010, 1'b0},
    {2'b11, 4'b0010, 24'h2ABCDE, 2'd1, 24'hAABCDE, 1'b0},
    {2'b10, 4'b1101, 24'hD00000, 2'd1, 24'hD00000, 1'b1}
  };

  task automatic check(string req, logic [23:0] exp_p, logic exp_w);
    n_chk++;
    if (addr_pins !== exp_p || bus_wide !== exp_w) begin
      n_fail++;
      $display("FAIL %s: pins=%h wide=%b expected pins=%h wide=%b",
               req, addr_pins, bus_wide, exp_p, exp_w);
    end
  endtask

  task automatic do_reset(logic strap);
    @(negedge clk);
    rst = 1'b1; byte_strap = strap; ext_req = 1'b0; cfg_we = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_cfg(logic [1:0] m, logic [3:0] b);
    cfg_we = 1'b1; cfg_cs_mode = m; cfg_byte_bus = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(logic [23:0] a, logic [1:0] s);
    ext_req = 1'b1; ext_addr = a; ext_space = s;
    @(negedge clk);
    ext_req = 1'b0;
  endtask

  initial begin
    do_reset(1'b1);
    check("R5 reset state", 24'h800000, 1'b0);
    // default mode 11 and strap-high space 3
    access(24'hF00000, 2'd3);
    check("R7 strap high gives 8-bit / R3 default mode", 24'h700000, 1'b0);
    access(24'hF00000, 2'd0);
    check("R7 space 0 resets 16-bit", 24'h700000, 1'b1);
    // R2 hold: address changes with strobe low
    ext_addr = 24'h123456; ext_space = 2'd3;
    @(negedge clk); @(negedge clk);
    check("R2 hold without strobe", 24'h700000, 1'b1);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      write_cfg(t[56:55], t[54:51]);
      access(t[50:27], t[26:25]);
      check($sformatf("R1/R3/R4/R6 vector %0d", v), t[24:1], t[0]);
    end

    // R8: write and access on the same edge
    write_cfg(2'b11, 4'b0000);
    ext_req = 1'b1; ext_addr = 24'hE00000; ext_space = 2'd2;
    cfg_we = 1'b1; cfg_cs_mode = 2'b00; cfg_byte_bus = 4'b0100;
    @(negedge clk);
    ext_req = 1'b0; cfg_we = 1'b0;
    check("R8 same-edge access uses old config", 24'h600000, 1'b1);
    access(24'hE00000, 2'd2);
    check("R8 next access uses new config", 24'hB00000, 1'b0);

    // R4 outside windows in mode 00, low pins distinct
    access(24'hB0F0F0, 2'd0);
    check("R4 outside windows all high", 24'hF0F0F0, 1'b1);

    do_reset(1'b0);
    check("R5 reset state again", 24'h800000, 1'b0);
    access(24'h000001, 2'd3);
    check("R7 strap low gives 16-bit", 24'h800001, 1'b1);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: done=0 expected done=1");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule